// File: doc/BRIEF.md
# Duplicate Track Removal Buffer

This block sits at the end of a track-fitting pipeline and thins out the candidate list of one event. Each candidate arrives with one cluster identifier per detector layer, a mask of the layers the fit actually used, and a chi-square quality value. The block holds the surviving candidates of the current event in a small buffer. Before a candidate is stored, it is compared with every track already held there, by counting the layers on which both tracks point to the same cluster. When that count reaches a programmable threshold, the two tracks are treated as the same particle and only the preferred one stays.

The input stream carries candidates and a separate end-of-event marker beat. When the marker is accepted, the block stops taking input. It plays the stored tracks out in slot order, then sends a marker beat of its own, then empties the buffer. Both streams use a valid/ready handshake.

Control is a four-state machine:
- `ST_ACCEPT` takes input. A candidate moves it to `ST_JUDGE`. A marker moves it to `ST_DRAIN`, or straight to `ST_MARK` when the buffer is empty.
- `ST_JUDGE` stores, overwrites or drops the candidate, then returns to `ST_ACCEPT`.
- `ST_DRAIN` emits one stored track per accepted beat. After the last one it moves to `ST_MARK`.
- `ST_MARK` emits the end-of-event beat. When that beat is accepted it clears the buffer and returns to `ST_ACCEPT`.

Top module: `trk_dedup_top`

## Requirements
- R1: After reset, `in_ready` is 1 and both `out_valid` and `ovf` are 0.
- R2: A layer is shared only when bit l of both masks is set and both cluster fields l (bits l*CLU_W and up) are equal. Two tracks are duplicates when the number of shared layers is at least `dup_thr`.
- R3: Between duplicates, the track using more layers (the population count of its mask) is preferred. With equal layer counts, the lower chi-square is preferred. On a full tie, the stored track is kept.
- R4: A newcomer preferred over the stored duplicate overwrites that slot in place, so it is emitted at that slot's position.
- R5: A newcomer that loses to a stored duplicate is discarded and the buffer is unchanged.
- R6: A newcomer with no duplicate goes into the next free slot while fewer than DEPTH tracks are held. Occupancy never exceeds DEPTH.
- R7: A newcomer with no duplicate that arrives while the buffer is full is discarded and `ovf` goes to 1. `ovf` stays 1 until the end-of-event output beat is accepted.
- R8: After an input beat with `in_eoe`=1, the stored tracks are emitted in slot order, followed by one beat with `out_eoe`=1. The buffer is empty and `ovf` is 0 once that beat is accepted. An empty event emits only the marker beat.
- R9: While `out_valid` is 1 and `out_ready` is 0, every output data field and `out_eoe` hold their values.
- R10: `in_ready` is 0 in the cycle after a candidate is accepted and throughout output, so input and output beats never coincide.
- R11: When a newcomer duplicates several stored tracks, it is kept only if it is preferred over all of them. It then replaces the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dup_thr | input | $clog2(LAYERS+1) | Shared-layer count that marks a duplicate |
| in_valid | input | 1 | Input beat valid |
| in_eoe | input | 1 | Input beat is the end-of-event marker (data ignored) |
| in_clu | input | LAYERS*CLU_W | Cluster identifiers, layer l at bits l*CLU_W |
| in_chi | input | CHI_W | Chi-square of the candidate |
| in_mask | input | LAYERS | Layers used by the fit |
| in_ready | output | 1 | Block accepts an input beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_eoe | output | 1 | Output beat is the end-of-event marker |
| out_clu | output | LAYERS*CLU_W | Cluster identifiers of the emitted track |
| out_chi | output | CHI_W | Chi-square of the emitted track |
| out_mask | output | LAYERS | Layer mask of the emitted track |
| ovf | output | 1 | A track was lost to a full buffer in this event |

## Verification
The cycle-level checks cover the handshake and the occupancy rules:
- input and output beats never overlap;
- output beats hold still under back-pressure;
- occupancy stays within DEPTH and grows by at most one per cycle;
- the overflow flag only rises with a full buffer and holds until the end-of-event beat is taken;
- the buffer and flag are clear after that beat.

Which track survives a duplicate pair, where it lands, and the ordering of the emitted list can only be shown by the bench. It compares each event's output against a reference model of the shared-layer count and the preference order. The scenarios cover ties, multiple duplicates, overflow and empty events.

// File: rtl/trk_dedup_pkg.sv
package trk_dedup_pkg;
    typedef enum logic [1:0] {
        ST_ACCEPT,
        ST_JUDGE,
        ST_DRAIN,
        ST_MARK
    } dd_state_e;
endpackage

// File: rtl/trk_match_unit.sv
// Compares the held newcomer with one stored track: shared-layer count
// against threshold, and whether the newcomer is preferred.
module trk_match_unit #(
    parameter int LAYERS = 8,
    parameter int CLU_W  = 10,
    parameter int CHI_W  = 12,
    localparam int CNT_W = $clog2(LAYERS + 1)
) (
    input  logic [LAYERS*CLU_W-1:0] a_clu,
    input  logic [CHI_W-1:0]        a_chi,
    input  logic [LAYERS-1:0]       a_mask,
    input  logic [LAYERS*CLU_W-1:0] b_clu,
    input  logic [CHI_W-1:0]        b_chi,
    input  logic [LAYERS-1:0]       b_mask,
    input  logic [CNT_W-1:0]        thr,
    output logic                    is_dup,
    output logic                    a_wins
);
    logic [CNT_W-1:0] shared_n;
    logic [CNT_W-1:0] a_used;
    logic [CNT_W-1:0] b_used;

    always_comb begin
        shared_n = '0;
        a_used   = '0;
        b_used   = '0;
        for (int l = 0; l < LAYERS; l++) begin
            if (a_mask[l] && b_mask[l] &&
                (a_clu[l*CLU_W +: CLU_W] == b_clu[l*CLU_W +: CLU_W]))
                shared_n = shared_n + CNT_W'(1);
            if (a_mask[l]) a_used = a_used + CNT_W'(1);
            if (b_mask[l]) b_used = b_used + CNT_W'(1);
        end
        is_dup = (shared_n >= thr);
        a_wins = (a_used > b_used) || ((a_used == b_used) && (a_chi < b_chi));
    end
endmodule

// File: rtl/trk_slot_pick.sv
// Reduces per-slot comparison results to one decision.
module trk_slot_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] occ,
    input  logic [DEPTH-1:0] dup,
    input  logic [DEPTH-1:0] win,
    output logic             any_dup,
    output logic             nc_keep,
    output logic [IDX_W-1:0] first_dup
);
    logic [DEPTH-1:0] hit;

    always_comb begin
        hit       = occ & dup;
        any_dup   = |hit;
        nc_keep   = ~|(hit & ~win);
        first_dup = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) first_dup = IDX_W'(i);
        end
    end
endmodule

// File: rtl/trk_dedup_top.sv
module trk_dedup_top
    import trk_dedup_pkg::*;
#(
    parameter int LAYERS = 8,
    parameter int CLU_W  = 10,
    parameter int CHI_W  = 12,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(LAYERS + 1),
    localparam int IDX_W = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH + 1),
    localparam int TC_W  = LAYERS * CLU_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  dup_thr,
    input  logic              in_valid,
    input  logic              in_eoe,
    input  logic [TC_W-1:0]   in_clu,
    input  logic [CHI_W-1:0]  in_chi,
    input  logic [LAYERS-1:0] in_mask,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_eoe,
    output logic [TC_W-1:0]   out_clu,
    output logic [CHI_W-1:0]  out_chi,
    output logic [LAYERS-1:0] out_mask,
    output logic              ovf
);
    dd_state_e state, state_nx;

    logic [TC_W-1:0]   nc_clu;
    logic [CHI_W-1:0]  nc_chi;
    logic [LAYERS-1:0] nc_mask;

    logic [TC_W-1:0]   ent_clu  [DEPTH];
    logic [CHI_W-1:0]  ent_chi  [DEPTH];
    logic [LAYERS-1:0] ent_mask [DEPTH];

    logic [OCC_W-1:0]  occ_n;
    logic [IDX_W-1:0]  rd_idx;
    logic              ovf_q;

    logic [DEPTH-1:0]  occ_v, dup_v, win_v;
    logic              any_dup, nc_keep;
    logic [IDX_W-1:0]  first_dup;

    logic              last_rd;
    logic              full;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            assign occ_v[g] = (OCC_W'(g) < occ_n);
            trk_match_unit #(
                .LAYERS(LAYERS), .CLU_W(CLU_W), .CHI_W(CHI_W)
            ) u_match (
                .a_clu (nc_clu),     .a_chi (nc_chi),     .a_mask(nc_mask),
                .b_clu (ent_clu[g]), .b_chi (ent_chi[g]), .b_mask(ent_mask[g]),
                .thr   (dup_thr),
                .is_dup(dup_v[g]),
                .a_wins(win_v[g])
            );
        end
    endgenerate

    trk_slot_pick #(.DEPTH(DEPTH)) u_pick (
        .occ      (occ_v),
        .dup      (dup_v),
        .win      (win_v),
        .any_dup  (any_dup),
        .nc_keep  (nc_keep),
        .first_dup(first_dup)
    );

    assign last_rd = (OCC_W'(rd_idx) + OCC_W'(1) == occ_n);
    assign full    = (occ_n == OCC_W'(DEPTH));

    // Judgement: overwrite a beaten duplicate, or append when unique and room.
    always_comb begin
        wr_en  = 1'b0;
        wr_idx = IDX_W'(occ_n);
        if (state == ST_JUDGE) begin
            if (any_dup) begin
                wr_en  = nc_keep;
                wr_idx = first_dup;
            end else if (!full) begin
                wr_en = 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACCEPT: if (in_valid) begin
                if (in_eoe) state_nx = (occ_n == '0) ? ST_MARK : ST_DRAIN;
                else        state_nx = ST_JUDGE;
            end
            ST_JUDGE:  state_nx = ST_ACCEPT;
            ST_DRAIN:  if (out_ready && last_rd) state_nx = ST_MARK;
            ST_MARK:   if (out_ready) state_nx = ST_ACCEPT;
            default:   state_nx = ST_ACCEPT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ACCEPT;
        else        state <= state_nx;
    end

    // Control counters and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_n  <= '0;
            rd_idx <= '0;
            ovf_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_JUDGE: begin
                    if (!any_dup) begin
                        if (!full) occ_n <= occ_n + OCC_W'(1);
                        else       ovf_q <= 1'b1;
                    end
                end
                ST_DRAIN: if (out_ready) rd_idx <= last_rd ? '0 : rd_idx + IDX_W'(1);
                ST_MARK: if (out_ready) begin
                    occ_n  <= '0;
                    ovf_q  <= 1'b0;
                    rd_idx <= '0;
                end
                default: ;
            endcase
        end
    end

    // Newcomer holding register
    always_ff @(posedge clk) begin
        if (state == ST_ACCEPT && in_valid && !in_eoe) begin
            nc_clu  <= in_clu;
            nc_chi  <= in_chi;
            nc_mask <= in_mask;
        end
    end

    // Track storage
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_clu[wr_idx]  <= nc_clu;
            ent_chi[wr_idx]  <= nc_chi;
            ent_mask[wr_idx] <= nc_mask;
        end
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_eoe   = 1'b0;
        unique case (state)
            ST_ACCEPT: in_ready = 1'b1;
            ST_JUDGE:  ;
            ST_DRAIN:  out_valid = 1'b1;
            ST_MARK: begin
                out_valid = 1'b1;
                out_eoe   = 1'b1;
            end
            default:   ;
        endcase
        out_clu  = ent_clu[rd_idx];
        out_chi  = ent_chi[rd_idx];
        out_mask = ent_mask[rd_idx];
        ovf      = ovf_q;
    end
endmodule

// File: rtl/trk_dedup_chk.sv
module trk_dedup_chk #(
    parameter int LAYERS = 8,
    parameter int CLU_W  = 10,
    parameter int CHI_W  = 12,
    parameter int DEPTH  = 8,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic                    out_eoe,
    input logic [LAYERS*CLU_W-1:0] out_clu,
    input logic [CHI_W-1:0]        out_chi,
    input logic [LAYERS-1:0]       out_mask,
    input logic                    ovf,
    input logic [OCC_W-1:0]        occ_n
);
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_eoe) &&
            $stable(out_clu) && $stable(out_chi) && $stable(out_mask)));

    a_r6_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ_n <= OCC_W'(DEPTH));

    a_r6_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_n != $past(occ_n)) |-> ((occ_n == $past(occ_n) + OCC_W'(1)) || (occ_n == '0)));

    a_r7_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (occ_n == OCC_W'(DEPTH)));

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(out_valid && out_eoe && out_ready)) |=> ovf);

    a_r8_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eoe && out_ready) |=> ((occ_n == '0) && !ovf));
endmodule

bind trk_dedup_top trk_dedup_chk #(
    .LAYERS(LAYERS), .CLU_W(CLU_W), .CHI_W(CHI_W), .DEPTH(DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_eoe  (out_eoe),
    .out_clu  (out_clu),
    .out_chi  (out_chi),
    .out_mask (out_mask),
    .ovf      (ovf),
    .occ_n    (occ_n)
);

// File: tb/trk_dedup_top_test.sv
`timescale 1ns/1ps
module trk_dedup_top_test;
    localparam int LAYERS = 4;
    localparam int CLU_W  = 3;
    localparam int CHI_W  = 6;
    localparam int DEPTH  = 4;
    localparam int CNT_W  = $clog2(LAYERS + 1);
    localparam int TC_W   = LAYERS * CLU_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  dup_thr = '0;
    logic              in_valid = 1'b0;
    logic              in_eoe = 1'b0;
    logic [TC_W-1:0]   in_clu = '0;
    logic [CHI_W-1:0]  in_chi = '0;
    logic [LAYERS-1:0] in_mask = '0;
    logic              in_ready;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic              out_eoe;
    logic [TC_W-1:0]   out_clu;
    logic [CHI_W-1:0]  out_chi;
    logic [LAYERS-1:0] out_mask;
    logic              ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    trk_dedup_top #(
        .LAYERS(LAYERS), .CLU_W(CLU_W), .CHI_W(CHI_W), .DEPTH(DEPTH)
    ) uut (
        .clk(clk), .rst_n(rst_n), .dup_thr(dup_thr),
        .in_valid(in_valid), .in_eoe(in_eoe), .in_clu(in_clu),
        .in_chi(in_chi), .in_mask(in_mask), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_eoe(out_eoe),
        .out_clu(out_clu), .out_chi(out_chi), .out_mask(out_mask), .ovf(ovf)
    );

    // Reference model state
    logic [TC_W-1:0]   m_clu  [DEPTH];
    logic [CHI_W-1:0]  m_chi  [DEPTH];
    logic [LAYERS-1:0] m_mask [DEPTH];
    int                m_n;
    bit                m_ovf;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int shared_layers(logic [TC_W-1:0] ac, logic [LAYERS-1:0] am,
                                         logic [TC_W-1:0] bc, logic [LAYERS-1:0] bm);
        int s = 0;
        for (int l = 0; l < LAYERS; l++)
            if (am[l] && bm[l] && ac[l*CLU_W +: CLU_W] == bc[l*CLU_W +: CLU_W]) s++;
        return s;
    endfunction

    function automatic bit prefers(logic [CHI_W-1:0] ach, logic [LAYERS-1:0] am,
                                   logic [CHI_W-1:0] bch, logic [LAYERS-1:0] bm);
        int na = $countones(am);
        int nb = $countones(bm);
        return (na > nb) || (na == nb && ach < bch);
    endfunction

    task automatic model_apply(logic [TC_W-1:0] c, logic [CHI_W-1:0] x,
                               logic [LAYERS-1:0] m, int thr);
        int first = -1;
        bit lose = 0;
        for (int i = 0; i < m_n; i++) begin
            if (shared_layers(c, m, m_clu[i], m_mask[i]) >= thr) begin
                if (first < 0) first = i;
                if (!prefers(x, m, m_chi[i], m_mask[i])) lose = 1;
            end
        end
        if (first >= 0) begin
            if (!lose) begin
                m_clu[first] = c; m_chi[first] = x; m_mask[first] = m;
            end
        end else if (m_n < DEPTH) begin
            m_clu[m_n] = c; m_chi[m_n] = x; m_mask[m_n] = m; m_n++;
        end else begin
            m_ovf = 1;
        end
    endtask

    task automatic push(bit eoe, logic [TC_W-1:0] c, logic [CHI_W-1:0] x,
                        logic [LAYERS-1:0] m);
        @(negedge clk);
        in_valid = 1'b1; in_eoe = eoe; in_clu = c; in_chi = x; in_mask = m;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_eoe = 1'b0;
        check(in_ready == 1'b0, "R10", "in_ready after accepted beat", in_ready, 0);
    endtask

    task automatic cand(logic [TC_W-1:0] c, logic [CHI_W-1:0] x,
                        logic [LAYERS-1:0] m);
        push(1'b0, c, x, m);
        model_apply(c, x, m, int'(dup_thr));
    endtask

    task automatic start_event(int thr);
        m_n = 0; m_ovf = 0;
        dup_thr = CNT_W'(thr);
    endtask

    task automatic finish_event(string req, bit bp);
        int idx = 0;
        bit done = 0;
        bit held = 0;
        logic [TC_W-1:0] h_clu; logic [CHI_W-1:0] h_chi;
        logic [LAYERS-1:0] h_mask; logic h_eoe;
        push(1'b1, '0, '0, '0);
        while (!done) begin
            @(negedge clk);
            if (held && out_valid)
                check(out_clu == h_clu && out_chi == h_chi && out_mask == h_mask &&
                      out_eoe == h_eoe, "R9", "beat changed under back-pressure",
                      {out_eoe, out_clu}, {h_eoe, h_clu});
            held = 0;
            out_ready = bp ? (($urandom % 3) != 0) : 1'b1;
            if (out_valid) begin
                if (out_ready) begin
                    if (idx < m_n) begin
                        check(!out_eoe, "R8", "marker too early", out_eoe, 0);
                        check(out_clu == m_clu[idx], req, "clusters", out_clu, m_clu[idx]);
                        check(out_chi == m_chi[idx], req, "chi2", out_chi, m_chi[idx]);
                        check(out_mask == m_mask[idx], req, "mask", out_mask, m_mask[idx]);
                    end else begin
                        check(out_eoe, "R8", "marker after tracks", out_eoe, 1);
                        check(ovf == m_ovf, "R7", "ovf at marker", ovf, m_ovf);
                        done = 1;
                    end
                    idx++;
                end else begin
                    held = 1; h_clu = out_clu; h_chi = out_chi;
                    h_mask = out_mask; h_eoe = out_eoe;
                end
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        check(in_ready && !out_valid && !ovf, "R8", "cleared after marker",
              {in_ready, out_valid, ovf}, 3'b100);
    endtask

    function automatic logic [TC_W-1:0] pack4(int a, int b, int c, int d);
        return {CLU_W'(d), CLU_W'(c), CLU_W'(b), CLU_W'(a)};
    endfunction

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid && !ovf, "R1", "reset outputs",
              {in_ready, out_valid, ovf}, 3'b100);

        // R3 R4: better newcomer overwrites slot 0; unique one appended (R6)
        start_event(2);
        cand(pack4(1,1,1,1), 30, 4'b1111);
        cand(pack4(2,2,2,2), 20, 4'b0111);
        cand(pack4(1,1,1,1), 10, 4'b1111);
        finish_event("R4", 0);

        // R3 tie keeps stored; more layers beats lower chi2 (R5 drop)
        start_event(3);
        cand(pack4(1,2,3,4), 20, 4'b1111);
        cand(pack4(1,2,3,5), 20, 4'b1111);
        cand(pack4(5,5,5,0), 60, 4'b1111);
        cand(pack4(5,5,5,6), 1,  4'b0111);
        finish_event("R3", 1);

        // R2: sharing below threshold keeps both; masked-off equal layers not shared
        start_event(3);
        cand(pack4(1,1,3,3), 9, 4'b1111);
        cand(pack4(1,1,4,4), 2, 4'b1111);
        cand(pack4(1,1,3,3), 1, 4'b0011);
        finish_event("R2", 0);

        // R11: newcomer beats two duplicates, lands in lowest slot
        start_event(2);
        cand(pack4(1,1,2,2), 40, 4'b1111);
        cand(pack4(3,3,4,4), 40, 4'b1111);
        cand(pack4(1,1,4,4), 10, 4'b1111);
        cand(pack4(3,3,2,2), 50, 4'b1111);
        finish_event("R11", 1);

        // R7: overflow when full
        start_event(1);
        for (int i = 0; i < 6; i++) cand(pack4(i, i, i, i), CHI_W'(i), 4'b1111);
        check(ovf == 1'b1, "R7", "ovf raised when full", ovf, 1);
        finish_event("R6", 1);

        // R8: empty event emits marker only
        start_event(2);
        finish_event("R8", 0);

        // Random events (R5 R6 R3 mixed)
        for (int e = 0; e < 40; e++) begin
            start_event(1 + int'($urandom % LAYERS));
            for (int k = 0; k < int'($urandom % 9); k++) begin
                logic [LAYERS-1:0] mk;
                mk = LAYERS'($urandom);
                if (mk == '0) mk = 4'b0001;
                cand(pack4(int'($urandom % 3), int'($urandom % 3),
                           int'($urandom % 3), int'($urandom % 3)),
                     CHI_W'($urandom % 8), mk);
            end
            finish_event("R5", 1);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule